// File: doc/BRIEF.md
# Mode-Selectable Synchronous Clock Divider Tree

This block takes a single master clock and turns it into a family of derived clocks that all share rising edges: a processor clock, a half-rate memory reference, a nominal 66 MHz clock, a PCI clock and an interrupt-controller clock. A frequency-select pin and two mode pins form a three-bit code. The code chooses between high-rate (133) and low-rate (100) operation with the USB clock on or off, an all-outputs-off state, and a test mode. In test mode the test clock is driven on the master clock input and every output becomes a fixed power-of-two fraction of it. Reserved codes act like the all-off code.

Each output is a registered waveform with its own enable. Downstream pad logic uses the enable to three-state the pin. The USB and reference clocks come from sources outside the block and are passed through under control of their enables. The only exception is test mode, where the USB output is generated by a divider. In the run modes the master clock is four times the processor rate, and every divisor is even, so every divided output has a 50% duty cycle.

All dividers restart together at the start of each common period: 32 master cycles at 133, 24 at 100, 16 in test. A new select code is adopted only at such a boundary, so a ratio change never produces a runt pulse. It also keeps every output phase-aligned to the processor clock.

Top module: `clock_divider_tree`

## Requirements
- R1: While rstN is low, every waveform output and every enable output is 0. Once reset is released the block is in the all-off state.
- R2: Code {freqSel,modeSel[1],modeSel[0]} = 000 drives every waveform and every enable to 0.
- R3: The reserved codes 001 and 101 behave exactly like code 000.
- R4: Codes 110 and 111 (133 operation) give these periods in master cycles: processor 4, memory 8, 66 MHz 8, PCI 16, interrupt 32. Each is high for the first half of its period, and the five enables are 1.
- R5: Codes 010 and 011 (100 operation) give these periods in master cycles: processor 4, memory 8, 66 MHz 6, PCI 12, interrupt 24. Each is high for the first half of its period, and the five enables are 1.
- R6: Code 100 (test) gives these periods in master cycles: processor 2, memory 4, 66 MHz 4, PCI 8, interrupt 16, USB 2. All enables are 1.
- R7: In the run modes, modeSel[0]=1 sets usbEn=1 and usbClk follows usbIn. With modeSel[0]=0, usbEn=0 and usbClk=0.
- R8: In the run and test modes, refEn=1 and refClk follows refIn. In the off state both are 0.
- R9: On the first master edge of every common period, all five divided waveforms rise together.
- R10: A new code takes effect only at the end of the current common period (32, 24 or 16 master cycles). In the off state a new code is adopted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (test clock in test mode) |
| rstN | input | 1 | Asynchronous active-low reset |
| freqSel | input | 1 | 1 selects 133 operation, 0 selects 100 |
| modeSel | input | 2 | Mode bits; bit 0 enables USB in run modes |
| usbIn | input | 1 | External 48 MHz source |
| refIn | input | 1 | External reference source |
| cpuClk | output | 1 | Processor clock waveform |
| memClk | output | 1 | Half-rate memory reference waveform |
| clk66 | output | 1 | 66 MHz waveform |
| pciClk | output | 1 | PCI waveform |
| apicClk | output | 1 | Interrupt-controller waveform |
| usbClk | output | 1 | USB clock waveform |
| refClk | output | 1 | Reference clock waveform |
| cpuEn | output | 1 | Drive enable for cpuClk |
| memEn | output | 1 | Drive enable for memClk |
| en66 | output | 1 | Drive enable for clk66 |
| pciEn | output | 1 | Drive enable for pciClk |
| apicEn | output | 1 | Drive enable for apicClk |
| usbEn | output | 1 | Drive enable for usbClk |
| refEn | output | 1 | Drive enable for refClk |

## Verification
The hardest situation to reach is a code change that lands partway through a long common period, including several changes before the boundary arrives. Only the last of those changes may win, and the old ratios must continue until the boundary. The stimulus changes the code at irregular cycle counts relative to the 32-, 24- and 16-cycle periods, sometimes twice within one period. It also applies a reset in mid-run. A behavioural model tracks the pending code and the position within the period, and it compares every output on every cycle.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_RUN_HI = 2'd1,
    MODE_RUN_LO = 2'd2,
    MODE_TEST   = 2'd3
  } modeKindT;

  typedef struct packed {
    modeKindT kind;
    logic     usbOn;
  } modeT;

  typedef struct packed {
    logic restart;
    modeT mode;
  } ctlStrobeT;

  localparam int NUM_DIV  = 6;
  localparam int IDX_CPU  = 0;
  localparam int IDX_MEM  = 1;
  localparam int IDX_66   = 2;
  localparam int IDX_PCI  = 3;
  localparam int IDX_APIC = 4;
  localparam int IDX_USB  = 5;

  function automatic modeT decodeSel(logic fSel, logic [1:0] mSel);
    modeT m;
    m.kind  = MODE_OFF;
    m.usbOn = 1'b0;
    case ({fSel, mSel})
      3'b010: m.kind = MODE_RUN_LO;
      3'b011: begin m.kind = MODE_RUN_LO; m.usbOn = 1'b1; end
      3'b110: m.kind = MODE_RUN_HI;
      3'b111: begin m.kind = MODE_RUN_HI; m.usbOn = 1'b1; end
      3'b100: m.kind = MODE_TEST;
      default: m.kind = MODE_OFF;
    endcase
    return m;
  endfunction

  // Common period in master cycles: LCM of all divisors in that mode.
  function automatic int unsigned periodOf(modeKindT k, int unsigned ratio);
    case (k)
      MODE_RUN_HI: return 8 * ratio;
      MODE_RUN_LO: return 6 * ratio;
      MODE_TEST:   return 16;
      default:     return 1;
    endcase
  endfunction

  function automatic int unsigned divisorOf(modeKindT k, int idx, int unsigned ratio);
    int unsigned d;
    d = 2;
    case (k)
      MODE_RUN_HI: case (idx)
        IDX_CPU:  d = ratio;
        IDX_MEM:  d = 2 * ratio;
        IDX_66:   d = 2 * ratio;
        IDX_PCI:  d = 4 * ratio;
        IDX_APIC: d = 8 * ratio;
        default:  d = 2;
      endcase
      MODE_RUN_LO: case (idx)
        IDX_CPU:  d = ratio;
        IDX_MEM:  d = 2 * ratio;
        IDX_66:   d = (3 * ratio) / 2;
        IDX_PCI:  d = 3 * ratio;
        IDX_APIC: d = 6 * ratio;
        default:  d = 2;
      endcase
      MODE_TEST: case (idx)
        IDX_CPU:  d = 2;
        IDX_MEM:  d = 4;
        IDX_66:   d = 4;
        IDX_PCI:  d = 8;
        IDX_APIC: d = 16;
        default:  d = 2;
      endcase
      default: d = 2;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/clk_tree_ctrl.sv
module clk_tree_ctrl
  import clk_tree_pkg::*;
#(
  parameter int unsigned RATIO = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freqSel,
  input  logic [1:0] modeSel,
  output ctlStrobeT  strobe
);

  localparam int CW = $clog2(8 * RATIO + 1);

  logic [CW-1:0] phase;
  logic [CW-1:0] lastPhase;
  modeT          curMode;

  always_comb begin
    lastPhase      = CW'(periodOf(curMode.kind, RATIO) - 1);
    strobe.restart = (phase == lastPhase);
    strobe.mode    = strobe.restart ? decodeSel(freqSel, modeSel) : curMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase         <= '0;
      curMode.kind  <= MODE_OFF;
      curMode.usbOn <= 1'b0;
    end else if (strobe.restart) begin
      phase   <= '0;
      curMode <= strobe.mode;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // R10
  phase_in_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase <= lastPhase);

  // R10
  mode_held_mid_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.restart |=> $stable(curMode));

endmodule

// File: rtl/clk_tree_dp.sv
module clk_tree_dp
  import clk_tree_pkg::*;
#(
  parameter int unsigned RATIO = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobeT          strobe,
  output logic [NUM_DIV-1:0] divQ,
  output logic               runEn,
  output logic               usbEnable,
  output logic               refEnable,
  output logic               testOn
);

  localparam int CW = $clog2(8 * RATIO + 1);

  logic active;
  assign active = (strobe.mode.kind != MODE_OFF);

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    logic [CW-1:0] cnt;
    logic [CW-1:0] divisor;
    logic [CW-1:0] half;
    logic [CW-1:0] cntNext;

    always_comb begin
      divisor = CW'(divisorOf(strobe.mode.kind, i, RATIO));
      half    = divisor >> 1;
      cntNext = (cnt == divisor - CW'(1)) ? '0 : cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt     <= '0;
        divQ[i] <= 1'b0;
      end else if (strobe.restart) begin
        cnt     <= '0;
        divQ[i] <= active;
      end else begin
        cnt     <= cntNext;
        divQ[i] <= active && (cntNext < half);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      usbEnable <= 1'b0;
      refEnable <= 1'b0;
      testOn    <= 1'b0;
    end else if (strobe.restart) begin
      runEn     <= active;
      refEnable <= active;
      testOn    <= (strobe.mode.kind == MODE_TEST);
      usbEnable <= (strobe.mode.kind == MODE_TEST) ||
                   (active && strobe.mode.usbOn);
    end
  end

  // R9
  common_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.restart && active) |=> (&divQ));

  // R2
  off_means_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (divQ == '0));

  // R8
  ref_follows_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    refEnable == runEn);

endmodule

// File: rtl/clock_divider_tree.sv
module clock_divider_tree
  import clk_tree_pkg::*;
#(
  parameter int unsigned RATIO = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freqSel,
  input  logic [1:0] modeSel,
  input  logic       usbIn,
  input  logic       refIn,
  output logic       cpuClk,
  output logic       memClk,
  output logic       clk66,
  output logic       pciClk,
  output logic       apicClk,
  output logic       usbClk,
  output logic       refClk,
  output logic       cpuEn,
  output logic       memEn,
  output logic       en66,
  output logic       pciEn,
  output logic       apicEn,
  output logic       usbEn,
  output logic       refEn
);

  ctlStrobeT          strobe;
  logic [NUM_DIV-1:0] divQ;
  logic               runEn;
  logic               usbEnable;
  logic               refEnable;
  logic               testOn;

  clk_tree_ctrl #(.RATIO(RATIO)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .freqSel (freqSel),
    .modeSel (modeSel),
    .strobe  (strobe)
  );

  clk_tree_dp #(.RATIO(RATIO)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .divQ      (divQ),
    .runEn     (runEn),
    .usbEnable (usbEnable),
    .refEnable (refEnable),
    .testOn    (testOn)
  );

  assign cpuClk  = divQ[IDX_CPU];
  assign memClk  = divQ[IDX_MEM];
  assign clk66   = divQ[IDX_66];
  assign pciClk  = divQ[IDX_PCI];
  assign apicClk = divQ[IDX_APIC];
  assign usbClk  = testOn ? divQ[IDX_USB] : (usbEnable & usbIn);
  assign refClk  = refEnable & refIn;

  assign cpuEn  = runEn;
  assign memEn  = runEn;
  assign en66   = runEn;
  assign pciEn  = runEn;
  assign apicEn = runEn;
  assign usbEn  = usbEnable;
  assign refEn  = refEnable;

  // R7
  usb_quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !usbEnable |-> !usbClk);

endmodule

// File: tb/clock_divider_tree_test.sv
module clock_divider_tree_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       freqSel = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       usbIn = 1'b0;
  logic       refIn = 1'b0;
  logic cpuClk, memClk, clk66, pciClk, apicClk, usbClk, refClk;
  logic cpuEn, memEn, en66, pciEn, apicEn, usbEn, refEn;

  clock_divider_tree uut (
    .clk(clk), .rstN(rstN), .freqSel(freqSel), .modeSel(modeSel),
    .usbIn(usbIn), .refIn(refIn),
    .cpuClk(cpuClk), .memClk(memClk), .clk66(clk66), .pciClk(pciClk),
    .apicClk(apicClk), .usbClk(usbClk), .refClk(refClk),
    .cpuEn(cpuEn), .memEn(memEn), .en66(en66), .pciEn(pciEn),
    .apicEn(apicEn), .usbEn(usbEn), .refEn(refEn)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Behavioural reference: kind 0 off, 1 high-rate, 2 low-rate, 3 test.
  int mKind = 0;
  bit mUsb  = 1'b0;
  int mCode = 0;
  int t     = 0;

  function automatic int kindOf(int code);
    case (code)
      2, 3:    return 2;
      6, 7:    return 1;
      4:       return 3;
      default: return 0;
    endcase
  endfunction

  function automatic int periodExp(int k);
    case (k)
      1: return 32;
      2: return 24;
      3: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic int divExp(int k, int idx);
    int hi[5] = '{4, 8, 8, 16, 32};
    int lo[5] = '{4, 8, 6, 12, 24};
    int ts[5] = '{2, 4, 4, 8, 16};
    if (k == 1) return hi[idx];
    if (k == 2) return lo[idx];
    if (k == 3) return ts[idx];
    return 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mKind = 0; mUsb = 1'b0; mCode = 0; t = 0;
    end else if (mKind == 0 || t == periodExp(mKind) - 1) begin
      mCode = {freqSel, modeSel};
      mKind = kindOf(mCode);
      mUsb  = modeSel[0];
      t     = 0;
    end else begin
      t++;
    end
  end

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b (t=%0d kind=%0d)", req, what, act, exp, t, mKind);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string rq;
      string ru;
      bit    act;
      logic [4:0] wav;
      logic [4:0] ens;
      wav = {apicClk, pciClk, clk66, memClk, cpuClk};
      ens = {apicEn, pciEn, pciEn & 1'b0 | en66, memEn, cpuEn};
      act = (mKind != 0);
      if (!rstN) rq = "R1";
      else if (mCode != int'({freqSel, modeSel})) rq = "R10";
      else if (mKind == 0) rq = (mCode == 1 || mCode == 5) ? "R3" : "R2";
      else if (mKind == 1) rq = "R4";
      else if (mKind == 2) rq = "R5";
      else rq = "R6";
      if (!rstN) begin
        check(|{wav, usbClk, refClk}, 1'b0, "R1", "waveforms in reset");
        check(|{ens, usbEn, refEn}, 1'b0, "R1", "enables in reset");
      end else begin
        for (int i = 0; i < 5; i++) begin
          int d;
          d = divExp(mKind, i);
          check(wav[i], act && ((t % d) < d / 2), rq, $sformatf("waveform %0d", i));
        end
        check(cpuEn, act, rq, "cpuEn");
        check(memEn, act, rq, "memEn");
        check(en66,  act, rq, "en66");
        check(pciEn, act, rq, "pciEn");
        check(apicEn, act, rq, "apicEn");
        ru = (mKind == 3 || mKind == 0) ? rq : "R7";
        if (mKind == 3) check(usbClk, (t % 2) == 0, ru, "usbClk test");
        else check(usbClk, act && mUsb && usbIn, ru, "usbClk");
        check(usbEn, (mKind == 3) || (act && mUsb), ru, "usbEn");
        check(refClk, act && refIn, "R8", "refClk");
        check(refEn, act, "R8", "refEn");
        if (act && t == 0)
          check(&wav, 1'b1, "R9", "common rising edge");
      end
    end
  end

  // External source stimulus changes away from both edges.
  logic [7:0] lfsr = 8'hA5;
  always begin
    @(posedge clk);
    #2;
    lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    usbIn  = lfsr[0];
    refIn  = lfsr[3];
  end

  task automatic setCode(input int code, input int hold);
    @(posedge clk);
    #2;
    {freqSel, modeSel} = 3'(code);
    repeat (hold) @(posedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    setCode(0, 10);
    setCode(7, 75);
    setCode(3, 13);
    setCode(2, 61);
    setCode(6, 7);
    setCode(7, 4);
    setCode(6, 70);
    setCode(1, 40);
    setCode(5, 12);
    setCode(4, 45);
    setCode(2, 5);
    setCode(3, 9);
    setCode(0, 30);
    setCode(7, 50);
    @(posedge clk);
    #2 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    setCode(4, 37);
    setCode(6, 66);
    setCode(2, 53);
    setCode(0, 8);
    repeat (40) @(posedge clk);
    @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

endmodule